// File: doc/BRIEF.md
# Toggle-Bit Completion Poller

This engine runs on the host side and waits for a flash device to finish a byte program or a sector erase. The command sequence is issued elsewhere. Once its final write pulse has gone out (the fourth for a program, the sixth for an erase), the host pulses `start` with the byte address to poll and a read budget. The engine then issues single-byte reads to that address, one at a time. Each returned byte is compared with the one before it.

While the device is busy, bit 6 of every read flips. Two byte-identical reads in a row mean the operation has finished. If bit 5 (the device's failure flag) is set in a read where bit 6 has just flipped, the engine does not report failure at once. It takes two more reads, and reports failure only if bit 6 still flips between them. When the read budget runs out during normal polling, the engine reports a time-out.

Each outcome appears as a one-cycle pulse and is also held in a sticky status code until the next start. After a failure, a request output stays high. It asks the host to send the flash reset command, which clears the device's failure flag. The request path uses valid/ready: `rd_req_valid` and `rd_req_addr` stay stable until `rd_req_ready` is seen high. The response path also uses valid/ready: `rd_rsp_ready` is high only while the engine waits for the data of its single outstanding read, and a responder may hold off `rd_rsp_valid` for any number of cycles.

Top module: `toggle_poll_engine`

## Requirements
- R1: In idle, a `start` pulse latches `addr_in` and `max_reads`, raises `busy`, and every read of the run uses the latched address. A `start` while busy is ignored.
- R2: `rd_req_valid` stays high with a stable `rd_req_addr` until it is accepted. At most one read is outstanding. `rd_rsp_ready` is high only between request acceptance and response acceptance.
- R3: When two consecutive reads return identical bytes, the engine pulses `done_pulse`, sets `status_code` to 1 (OK) and returns to idle.
- R4: When bit 6 differs between consecutive reads and bit 5 of the newer read is 0, polling continues with another read.
- R5: When bit 6 differs and bit 5 of the newer read is 1, exactly two confirming reads follow, even if the read budget is spent. The result is failure if bit 6 differs between those two reads, and success otherwise.
- R6: Failure pulses `error_pulse`, sets `status_code` to 2 and raises `flash_reset_req`, which stays high until the next accepted start.
- R7: If a normal polling read neither completes nor enters confirmation, and the count of accepted reads has reached `max_reads`, the engine pulses `timeout_pulse` and sets `status_code` to 3. A budget of 0 or 1 times out after the first read.
- R8: At most one outcome pulse is high in any cycle, and each lasts one cycle. `status_code` holds its value until the next accepted start, which clears it to 0.
- R9: After reset the engine is idle, with no request, no pulses, `status_code` 0 and `flash_reset_req` low.
- R10: When consecutive reads differ only in bits other than bit 6, polling continues without any outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin polling (taken only when idle) |
| addr_in | input | AW | Byte address to poll |
| max_reads | input | CW | Read budget before time-out |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted by bus |
| rd_req_addr | output | AW | Read address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_ready | output | 1 | Engine waiting for read data |
| rd_rsp_data | input | DW | Read data byte |
| busy | output | 1 | Polling in progress |
| done_pulse | output | 1 | One-cycle success indication |
| error_pulse | output | 1 | One-cycle failure indication |
| timeout_pulse | output | 1 | One-cycle time-out indication |
| status_code | output | 2 | Sticky result: 0 none, 1 OK, 2 failure, 3 time-out |
| flash_reset_req | output | 1 | Request to issue the flash reset command |

## Verification
The assertions check the bus handshake rules on every cycle: the held request, the single outstanding read, and no request or response readiness while idle. They also check that outcome pulses are exclusive, that each pulse matches the status code, and that the reset request goes with every failure. Only the bench scenarios can show the decisions that depend on the data: identical-byte completion, the confirming reads with both possible endings, precedence of confirmation over the budget, time-out at budgets 0, 1 and 3, and polling that continues on changes outside bit 6. The bench also covers a start ignored mid-run and stalls on both handshake paths.

// File: rtl/tbp_pkg.sv
package tbp_pkg;
  typedef enum logic [1:0] {
    RES_NONE = 2'd0,
    RES_OK   = 2'd1,
    RES_FAIL = 2'd2,
    RES_TMO  = 2'd3
  } result_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_REQ,
    S_WAIT
  } fsm_e;

  typedef enum logic [1:0] {
    PH_FIRST,
    PH_POLL,
    PH_CONF1,
    PH_CONF2
  } phase_e;
endpackage

// File: rtl/tbp_compare.sv
module tbp_compare #(
  parameter int DW       = 8,
  parameter int TOG_BIT  = 6,
  parameter int FAIL_BIT = 5
) (
  input  logic [DW-1:0] prev_byte,
  input  logic [DW-1:0] cur_byte,
  output logic          same,
  output logic          toggled,
  output logic          fail_seen
);
  always_comb begin
    same      = (prev_byte == cur_byte);
    toggled   = prev_byte[TOG_BIT] ^ cur_byte[TOG_BIT];
    fail_seen = cur_byte[FAIL_BIT];
  end
endmodule

// File: rtl/tbp_read_cnt.sv
module tbp_read_cnt #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [CW-1:0] limit,
  output logic          reached
);
  logic [CW-1:0] cnt;
  logic [CW:0]   cnt_plus;

  always_comb begin
    cnt_plus = {1'b0, cnt} + {{CW{1'b0}}, 1'b1};
    reached  = (cnt_plus >= {1'b0, limit});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (clr) cnt <= '0;
    else if (inc && (cnt != {CW{1'b1}})) cnt <= cnt_plus[CW-1:0];
  end

  // R7: the count saturates instead of wrapping
  a_r7_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && cnt == {CW{1'b1}}) |=> cnt == {CW{1'b1}});
endmodule

// File: rtl/tbp_status.sv
module tbp_status
  import tbp_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clr,
  input  logic    fin,
  input  result_e fin_code,
  output logic    done_pulse,
  output logic    error_pulse,
  output logic    timeout_pulse,
  output result_e status_code,
  output logic    flash_reset_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_pulse      <= 1'b0;
      error_pulse     <= 1'b0;
      timeout_pulse   <= 1'b0;
      status_code     <= RES_NONE;
      flash_reset_req <= 1'b0;
    end else begin
      done_pulse    <= 1'b0;
      error_pulse   <= 1'b0;
      timeout_pulse <= 1'b0;
      if (clr) begin
        status_code     <= RES_NONE;
        flash_reset_req <= 1'b0;
      end else if (fin) begin
        status_code <= fin_code;
        case (fin_code)
          RES_OK:   done_pulse <= 1'b1;
          RES_FAIL: begin
            error_pulse     <= 1'b1;
            flash_reset_req <= 1'b1;
          end
          RES_TMO:  timeout_pulse <= 1'b1;
          default:  ;
        endcase
      end
    end
  end

  // R8: status only changes on clear or a finish
  a_r8_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !fin) |=> $stable(status_code));
  // R6: the reset request drops only at a clear
  a_r6_req_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_reset_req && !clr) |=> flash_reset_req);
endmodule

// File: rtl/toggle_poll_engine.sv
module toggle_poll_engine
  import tbp_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DW       = 8,
  parameter int CW       = 16,
  parameter int TOG_BIT  = 6,
  parameter int FAIL_BIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] addr_in,
  input  logic [CW-1:0] max_reads,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [AW-1:0] rd_req_addr,
  input  logic          rd_rsp_valid,
  output logic          rd_rsp_ready,
  input  logic [DW-1:0] rd_rsp_data,
  output logic          busy,
  output logic          done_pulse,
  output logic          error_pulse,
  output logic          timeout_pulse,
  output logic [1:0]    status_code,
  output logic          flash_reset_req
);
  fsm_e          state;
  phase_e        phase, phase_nxt;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] limit_q;
  logic [DW-1:0] prev_q;
  logic          take_start, accept;
  logic          same, toggled, fail_seen, reached;
  logic          fin;
  result_e       fin_code, status_e;

  assign take_start   = (state == S_IDLE) && start;
  assign accept       = (state == S_WAIT) && rd_rsp_valid;
  assign rd_req_valid = (state == S_REQ);
  assign rd_rsp_ready = (state == S_WAIT);
  assign rd_req_addr  = addr_q;
  assign busy         = (state != S_IDLE);
  assign status_code  = status_e;

  tbp_compare #(.DW(DW), .TOG_BIT(TOG_BIT), .FAIL_BIT(FAIL_BIT)) u_cmp (
    .prev_byte (prev_q),
    .cur_byte  (rd_rsp_data),
    .same      (same),
    .toggled   (toggled),
    .fail_seen (fail_seen)
  );

  tbp_read_cnt #(.CW(CW)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (take_start),
    .inc     (accept),
    .limit   (limit_q),
    .reached (reached)
  );

  always_comb begin
    fin       = 1'b0;
    fin_code  = RES_NONE;
    phase_nxt = phase;
    if (accept) begin
      case (phase)
        PH_FIRST: begin
          if (reached) begin
            fin = 1'b1; fin_code = RES_TMO;
          end else begin
            phase_nxt = PH_POLL;
          end
        end
        PH_POLL: begin
          if (same) begin
            fin = 1'b1; fin_code = RES_OK;
          end else if (toggled && fail_seen) begin
            phase_nxt = PH_CONF1;
          end else if (reached) begin
            fin = 1'b1; fin_code = RES_TMO;
          end
        end
        PH_CONF1: phase_nxt = PH_CONF2;
        default: begin
          fin      = 1'b1;
          fin_code = toggled ? RES_FAIL : RES_OK;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      phase   <= PH_FIRST;
      addr_q  <= '0;
      limit_q <= '0;
      prev_q  <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          addr_q  <= addr_in;
          limit_q <= max_reads;
          phase   <= PH_FIRST;
          state   <= S_REQ;
        end
        S_REQ: if (rd_req_ready) state <= S_WAIT;
        S_WAIT: if (rd_rsp_valid) begin
          prev_q <= rd_rsp_data;
          phase  <= phase_nxt;
          state  <= fin ? S_IDLE : S_REQ;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  tbp_status u_status (
    .clk             (clk),
    .rst_n           (rst_n),
    .clr             (take_start),
    .fin             (fin),
    .fin_code        (fin_code),
    .done_pulse      (done_pulse),
    .error_pulse     (error_pulse),
    .timeout_pulse   (timeout_pulse),
    .status_code     (status_e),
    .flash_reset_req (flash_reset_req)
  );

  // R2: request held with a stable address until accepted
  a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));
  // R2: never a new request while a response is awaited
  a_r2_single_read: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && rd_rsp_ready));
  // R1: idle issues nothing
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!rd_req_valid && !rd_rsp_ready));
  // R1: address constant while busy
  a_r1_addr_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(rd_req_addr));
  // R8: exclusive outcome pulses, each ending the run
  a_r8_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_pulse, error_pulse, timeout_pulse}));
  a_r8_pulse_short: assert property (@(posedge clk) disable iff (!rst_n)
    (done_pulse || error_pulse || timeout_pulse) |=>
      !(done_pulse || error_pulse || timeout_pulse));
  // R3
  a_r3_done_status: assert property (@(posedge clk) disable iff (!rst_n)
    done_pulse |-> (status_code == 2'd1 && !busy));
  // R6
  a_r6_err_status: assert property (@(posedge clk) disable iff (!rst_n)
    error_pulse |-> (status_code == 2'd2 && flash_reset_req));
  // R7
  a_r7_tmo_status: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_pulse |-> (status_code == 2'd3 && !busy));
endmodule

// File: tb/test_toggle_poll_engine.sv
module test_toggle_poll_engine;
  localparam int AW = 16;
  localparam int DW = 8;
  localparam int CW = 16;

  typedef struct packed {
    logic            restart;
    logic [1:0]      stall;
    logic [2:0]      n;
    logic [7:0]      maxr;
    logic [1:0]      code;
    logic [0:5][7:0] rd;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    // R3: immediate match
    '{1'b0, 2'd0, 3'd2, 8'd8, 2'd1, {8'h40, 8'h40, 8'h00, 8'h00, 8'h00, 8'h00}},
    // R4: toggles then settles
    '{1'b0, 2'd1, 3'd4, 8'd8, 2'd1, {8'h40, 8'h00, 8'h40, 8'h40, 8'h00, 8'h00}},
    // R5: confirm still toggling -> fail
    '{1'b0, 2'd0, 3'd4, 8'd8, 2'd2, {8'h00, 8'h60, 8'h20, 8'h60, 8'h00, 8'h00}},
    // R5: confirm steady -> ok
    '{1'b0, 2'd2, 3'd4, 8'd8, 2'd1, {8'h00, 8'h60, 8'h20, 8'h20, 8'h00, 8'h00}},
    // R7: budget 3
    '{1'b0, 2'd0, 3'd3, 8'd3, 2'd3, {8'h00, 8'h40, 8'h00, 8'h00, 8'h00, 8'h00}},
    // R7: budget 1
    '{1'b0, 2'd0, 3'd1, 8'd1, 2'd3, {8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}},
    // R7: budget 0
    '{1'b0, 2'd1, 3'd1, 8'd0, 2'd3, {8'h40, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00}},
    // R3: failure bit set but steady -> ok
    '{1'b0, 2'd0, 3'd2, 8'd8, 2'd1, {8'h60, 8'h60, 8'h00, 8'h00, 8'h00, 8'h00}},
    // R10: other bits change
    '{1'b0, 2'd0, 3'd3, 8'd8, 2'd1, {8'h21, 8'h22, 8'h22, 8'h00, 8'h00, 8'h00}},
    // R5: confirm beyond budget 2 -> ok
    '{1'b0, 2'd0, 3'd4, 8'd2, 2'd1, {8'h00, 8'h60, 8'h20, 8'h20, 8'h00, 8'h00}},
    // R5: confirm beyond budget 2 -> fail
    '{1'b0, 2'd1, 3'd4, 8'd2, 2'd2, {8'h00, 8'h60, 8'h20, 8'h60, 8'h00, 8'h00}},
    // R1: start while busy ignored
    '{1'b1, 2'd0, 3'd3, 8'd8, 2'd1, {8'h00, 8'h40, 8'h40, 8'h00, 8'h00, 8'h00}}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] addr_in = '0;
  logic [CW-1:0] max_reads = '0;
  logic          rd_req_valid;
  logic          rd_req_ready = 1'b0;
  logic [AW-1:0] rd_req_addr;
  logic          rd_rsp_valid = 1'b0;
  logic          rd_rsp_ready;
  logic [DW-1:0] rd_rsp_data = '0;
  logic          busy, done_pulse, error_pulse, timeout_pulse, flash_reset_req;
  logic [1:0]    status_code;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  toggle_poll_engine #(.AW(AW), .DW(DW), .CW(CW)) i_toggle_poll_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .addr_in(addr_in),
    .max_reads(max_reads), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
    .rd_rsp_data(rd_rsp_data), .busy(busy), .done_pulse(done_pulse),
    .error_pulse(error_pulse), .timeout_pulse(timeout_pulse),
    .status_code(status_code), .flash_reset_req(flash_reset_req)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic run_vec(input vec_t v, input logic [AW-1:0] a);
    int guard;
    @(negedge clk);
    addr_in   = a;
    max_reads = {8'd0, v.maxr};
    start     = 1'b1;
    @(negedge clk);
    start   = 1'b0;
    addr_in = ~a;
    check("R1 busy after start", busy, 1);
    check("R8 status cleared at start", status_code, 0);
    check("R6 reset request cleared at start", flash_reset_req, 0);
    for (int i = 0; i < int'(v.n); i++) begin
      guard = 0;
      while (!rd_req_valid && guard < 50) begin
        @(negedge clk);
        guard++;
      end
      check("R2 request issued", rd_req_valid, 1);
      check("R1 latched address", rd_req_addr, a);
      check("R10 no outcome while polling", {done_pulse, error_pulse, timeout_pulse}, 0);
      for (int s = 0; s < int'(v.stall); s++) @(negedge clk);
      if (v.restart && i == 1) begin
        addr_in = a ^ 16'h00ff;
        start   = 1'b1;
      end
      rd_req_ready = 1'b1;
      @(negedge clk);
      rd_req_ready = 1'b0;
      start        = 1'b0;
      check("R2 no request while awaiting data", rd_req_valid, 0);
      for (int s = 0; s < int'(v.stall); s++) @(negedge clk);
      check("R2 response ready while waiting", rd_rsp_ready, 1);
      rd_rsp_valid = 1'b1;
      rd_rsp_data  = v.rd[i];
      @(negedge clk);
      rd_rsp_valid = 1'b0;
    end
    case (v.code)
      2'd1: check("R3 done pulse", {done_pulse, error_pulse, timeout_pulse}, 3'b100);
      2'd2: check("R5 R6 error pulse", {done_pulse, error_pulse, timeout_pulse}, 3'b010);
      default: check("R7 timeout pulse", {done_pulse, error_pulse, timeout_pulse}, 3'b001);
    endcase
    check("R3 R7 idle after outcome", busy, 0);
    @(negedge clk);
    @(negedge clk);
    check("R8 pulses one cycle", {done_pulse, error_pulse, timeout_pulse}, 0);
    check("R8 sticky status", status_code, v.code);
    check("R6 reset request", flash_reset_req, (v.code == 2'd2));
    check("R2 no extra read", rd_req_valid, 0);
  endtask

  initial begin
    int cyc = 0;
    while (!finished && cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 idle", busy, 0);
    check("R9 no request", rd_req_valid, 0);
    check("R9 no pulses", {done_pulse, error_pulse, timeout_pulse}, 0);
    check("R9 status", status_code, 0);
    check("R9 reset request", flash_reset_req, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 still idle after release", busy, 0);
    for (int k = 0; k < NV; k++) run_vec(VECS[k], 16'h1000 + 16'(k * 3));
    // R8: status survives idle cycles until the next start
    repeat (5) @(negedge clk);
    check("R8 status held in idle", status_code, VECS[NV-1].code);
    finished = 1;
    summary();
  end
endmodule